// File: doc/BRIEF.md
# Period-Synchronized Slope Compensation Ramp

This block generates the digital reference for a 12-bit DAC that feeds a peak-current comparator. Each switching period it restarts the reference from a programmed start code, then moves it up or down so that across one period it travels a programmed number of DAC codes. Adding this ramp to the current threshold stabilizes a peak current mode loop at duty cycles above one half.

The restart comes from the rising edge of one line picked from a bank of PWM trigger lines. The per-clock step is the rate divided by the period length in clocks. It is held with 16 fractional bits, so rates smaller than the period length still accumulate correctly. Start code, rate, direction and step are captured at the restart edge, so the ramp in flight is not disturbed by register writes.

The output saturates at full scale or at zero. A system with several comparators instantiates one copy per comparator, up to eight, each with its own trigger choice and settings.

Top module: `slope_ramp_gen`

## Requirements
- R1: While `rst` is high, `ramp_o` is 0 and `ramp_valid_o` is 0.
- R2: With `cfg_enable_i` low, `ramp_o` equals `cfg_start_i` one clock later and `ramp_valid_o` is 0. Trigger edges are ignored while the enable is low.
- R3: With the enable high, on the first clock where trigger line number `cfg_sel_i` is sampled high after being sampled low, `ramp_o` becomes `cfg_start_i` at that clock edge. Edges on other lines, and a line held high, cause no restart.
- R4: At each later clock, a 28-bit accumulator (12 integer bits over 16 fractional bits) moves by step = floor(rate·65536 / period). `ramp_o` is its integer part, so after `period_clks_i` clocks the ramp has moved by the rate to within one code.
- R5: `cfg_falling_i` = 0 selects a rising ramp (step added) and 1 selects a falling ramp (step subtracted).
- R6: A rising ramp stops at 4095 and never wraps.
- R7: A falling ramp stops at 0 and never wraps.
- R8: Rate, period, direction and start are captured at the restart edge. Changing them mid-ramp has no effect until the next restart.
- R9: A restart that arrives mid-ramp reloads the start code and clears the fractional bits in that same clock.
- R10: A period length of 0 gives a step of 0, so the ramp holds at its start code.
- R11: `ramp_valid_o` rises with the first restart after the enable goes high, and stays high until the enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 12 | PWM trigger lines, synchronous to `clk` |
| cfg_enable_i | input | 1 | Ramp generation enable |
| cfg_falling_i | input | 1 | Direction: 0 rising, 1 falling |
| cfg_sel_i | input | 4 | Index of the trigger line used for restart |
| cfg_start_i | input | 12 | Start code of the ramp |
| cfg_rate_i | input | 8 | Codes travelled per period |
| period_clks_i | input | 16 | PWM period length in clocks |
| ramp_o | output | 12 | DAC reference code |
| ramp_valid_o | output | 1 | A ramp has been started and is being produced |

## Verification
A wrong step or a dropped fraction shows as a ramp code that drifts from the floor formula within a few clocks. For small rates it can take most of a period to surface, so some checks sample late in the period. A stale fraction after a restart shows up one or two clocks after the reload, as a code one above the start. A corrupted capture register shows as a changed slope or direction at the first sample after a mid-ramp write. A wrap shows as a jump to the opposite end of the range on the clock after saturation would be reached.

// File: rtl/slope_pkg.sv
package slope_pkg;
  typedef enum logic {
    RAMP_UP   = 1'b0,
    RAMP_DOWN = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/slope_trig_pick.sv
module slope_trig_pick #(
  parameter int N_TRIG = 12,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              edge_o
);
  logic [N_TRIG-1:0] trig_q;
  logic [N_TRIG-1:0] rise;

  always_ff @(posedge clk) begin
    if (rst) trig_q <= '0;
    else     trig_q <= trig_i;
  end

  for (genvar g = 0; g < N_TRIG; g++) begin : g_rise
    assign rise[g] = trig_i[g] & ~trig_q[g];
  end

  always_comb begin
    edge_o = 1'b0;
    if (int'(sel_i) < N_TRIG) edge_o = rise[sel_i];
  end
endmodule

// File: rtl/slope_step_div.sv
module slope_step_div #(
  parameter int RATE_W = 8,
  parameter int PER_W  = 16,
  parameter int FRAC_W = 16,
  parameter int STEP_W = RATE_W + FRAC_W
) (
  input  logic [RATE_W-1:0] rate_i,
  input  logic [PER_W-1:0]  period_i,
  output logic [STEP_W-1:0] step_o
);
  logic [STEP_W-1:0] num;
  logic [STEP_W-1:0] den;

  always_comb begin
    num = {rate_i, {FRAC_W{1'b0}}};
    den = STEP_W'(period_i);
    if (den == '0) step_o = '0;
    else           step_o = num / den;
  end
endmodule

// File: rtl/slope_accum.sv
module slope_accum
  import slope_pkg::*;
#(
  parameter int DAC_W  = 12,
  parameter int FRAC_W = 16,
  parameter int STEP_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [DAC_W-1:0]  start_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              down_i,
  output logic [DAC_W-1:0]  ramp_o,
  output logic              valid_o
);
  localparam int ACC_W = DAC_W + FRAC_W;
  localparam logic [ACC_W:0] ACC_MAX = {1'b0, {DAC_W{1'b1}}, {FRAC_W{1'b0}}};

  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  acc_nxt;
  logic [ACC_W-1:0]  step_ext;
  logic [ACC_W:0]    sum;
  logic [STEP_W-1:0] step_q;
  ramp_dir_e         dir_q;
  logic              valid_q;

  always_comb begin
    step_ext = ACC_W'(step_q);
    sum      = '0;
    if (dir_q == RAMP_DOWN) begin
      acc_nxt = (acc_q >= step_ext) ? acc_q - step_ext : '0;
    end else begin
      sum     = {1'b0, acc_q} + {1'b0, step_ext};
      acc_nxt = (sum > ACC_MAX) ? ACC_MAX[ACC_W-1:0] : sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      step_q  <= '0;
      dir_q   <= RAMP_UP;
      valid_q <= 1'b0;
    end else if (!en_i) begin
      acc_q   <= {start_i, {FRAC_W{1'b0}}};
      step_q  <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      acc_q   <= {start_i, {FRAC_W{1'b0}}};
      step_q  <= step_i;
      dir_q   <= down_i ? RAMP_DOWN : RAMP_UP;
      valid_q <= 1'b1;
    end else if (valid_q) begin
      acc_q   <= acc_nxt;
    end
  end

  assign ramp_o  = acc_q[ACC_W-1:FRAC_W];
  assign valid_o = valid_q;

  assert_load_start_R3: assert property (@(posedge clk) disable iff (rst)
    en_i && load_i |=> ramp_o == $past(start_i) && valid_o);
  assert_disable_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> ramp_o == $past(start_i) && !valid_o);
  assert_no_wrap_up_R6: assert property (@(posedge clk) disable iff (rst)
    en_i && !load_i && valid_o && dir_q == RAMP_UP |=> ramp_o >= $past(ramp_o));
  assert_no_wrap_down_R7: assert property (@(posedge clk) disable iff (rst)
    en_i && !load_i && valid_o && dir_q == RAMP_DOWN |=> ramp_o <= $past(ramp_o));
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    en_i && !load_i && valid_o |=> $stable(step_q) && $stable(dir_q));
  assert_valid_rise_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> $past(load_i) && $past(en_i));
endmodule

// File: rtl/slope_ramp_gen.sv
module slope_ramp_gen #(
  parameter int N_TRIG = 12,
  parameter int SEL_W  = $clog2(N_TRIG),
  parameter int DAC_W  = 12,
  parameter int RATE_W = 8,
  parameter int PER_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              cfg_enable_i,
  input  logic              cfg_falling_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [DAC_W-1:0]  cfg_start_i,
  input  logic [RATE_W-1:0] cfg_rate_i,
  input  logic [PER_W-1:0]  period_clks_i,
  output logic [DAC_W-1:0]  ramp_o,
  output logic              ramp_valid_o
);
  localparam int STEP_W = RATE_W + FRAC_W;

  logic              restart;
  logic [STEP_W-1:0] step;

  slope_trig_pick #(.N_TRIG(N_TRIG), .SEL_W(SEL_W)) trig_pick_i (
    .clk    (clk),
    .rst    (rst),
    .trig_i (trig_i),
    .sel_i  (cfg_sel_i),
    .edge_o (restart)
  );

  slope_step_div #(.RATE_W(RATE_W), .PER_W(PER_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) step_div_i (
    .rate_i   (cfg_rate_i),
    .period_i (period_clks_i),
    .step_o   (step)
  );

  slope_accum #(.DAC_W(DAC_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) accum_i (
    .clk     (clk),
    .rst     (rst),
    .en_i    (cfg_enable_i),
    .load_i  (restart),
    .start_i (cfg_start_i),
    .step_i  (step),
    .down_i  (cfg_falling_i),
    .ramp_o  (ramp_o),
    .valid_o (ramp_valid_o)
  );
endmodule

// File: tb/slope_ramp_gen_tb.sv
module slope_ramp_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] trig = '0;
  logic        en = 1'b0;
  logic        fall = 1'b0;
  logic [3:0]  sel = '0;
  logic [11:0] start = '0;
  logic [7:0]  rate = '0;
  logic [15:0] per = '0;
  logic [11:0] ramp;
  logic        valid;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  slope_ramp_gen dut_i (
    .clk(clk), .rst(rst), .trig_i(trig), .cfg_enable_i(en), .cfg_falling_i(fall),
    .cfg_sel_i(sel), .cfg_start_i(start), .cfg_rate_i(rate), .period_clks_i(per),
    .ramp_o(ramp), .ramp_valid_o(valid)
  );

  function automatic int exp_ramp(int st, int rt, int pd, bit dn, int k);
    longint step = (pd == 0) ? 0 : (longint'(rt) <<< 16) / pd;
    longint acc  = longint'(st) <<< 16;
    longint mx   = longint'(4095) <<< 16;
    for (int i = 0; i < k; i++) begin
      if (dn) acc = (acc >= step) ? acc - step : 0;
      else begin
        acc = acc + step;
        if (acc > mx) acc = mx;
      end
    end
    return int'(acc >>> 16);
  endfunction

  task automatic chk(string req, int got, int expv);
    total++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int idx);
    @(negedge clk); trig[idx] = 1'b1;
    @(negedge clk); trig[idx] = 1'b0;
  endtask

  task automatic setup(bit e, bit f, int s, int st, int rt, int pd);
    @(negedge clk);
    en = e; fall = f; sel = 4'(s); start = 12'(st); rate = 8'(rt); per = 16'(pd);
  endtask

  task automatic t_reset();
    wait_n(2);
    chk("R1 ramp", ramp, 0);
    chk("R1 valid", valid, 0);
    rst = 1'b0;
  endtask

  task automatic t_disabled();
    setup(0, 0, 3, 300, 74, 100);
    wait_n(2);
    chk("R2 ramp", ramp, 300);
    chk("R2 valid", valid, 0);
    pulse(3); wait_n(3);
    chk("R2 edge ignored ramp", ramp, 300);
    chk("R2 edge ignored valid", valid, 0);
  endtask

  task automatic t_rising();
    setup(1, 0, 3, 100, 74, 100);
    wait_n(1);
    chk("R11 valid before edge", valid, 0);
    pulse(3);
    chk("R3 start load", ramp, 100);
    chk("R11 valid", valid, 1);
    wait_n(50);
    chk("R4 mid period", ramp, exp_ramp(100, 74, 100, 0, 50));
    wait_n(50);
    chk("R4 full period", ramp, exp_ramp(100, 74, 100, 0, 100));
    chk("R4 within one code", (ramp - 100 >= 73) ? 1 : 0, 1);
  endtask

  task automatic t_falling();
    setup(1, 1, 3, 50, 200, 20);
    pulse(3);
    wait_n(3);
    chk("R5 falling", ramp, 20);
    wait_n(5);
    chk("R7 floor", ramp, 0);
    wait_n(4);
    chk("R7 no wrap", ramp, 0);
  endtask

  task automatic t_sat_up();
    setup(1, 0, 3, 4090, 255, 10);
    pulse(3);
    wait_n(1);
    chk("R6 clamp", ramp, 4095);
    wait_n(4);
    chk("R6 no wrap", ramp, 4095);
  endtask

  task automatic t_cfg_latch();
    setup(1, 0, 3, 200, 100, 50);
    pulse(3);
    wait_n(5);
    chk("R8 before write", ramp, exp_ramp(200, 100, 50, 0, 5));
    fall = 1'b1; rate = 8'd255; start = 12'd999; per = 16'd7;
    wait_n(5);
    chk("R8 write ignored", ramp, exp_ramp(200, 100, 50, 0, 10));
    pulse(3);
    chk("R8 new start at edge", ramp, 999);
    wait_n(2);
    chk("R8 new slope at edge", ramp, exp_ramp(999, 255, 7, 1, 2));
  endtask

  task automatic t_other_line();
    setup(1, 0, 3, 10, 100, 50);
    pulse(3);
    wait_n(4);
    pulse(0);
    chk("R3 other line ignored", ramp, exp_ramp(10, 100, 50, 0, 6));
    @(negedge clk); trig[3] = 1'b1;
    @(negedge clk);
    chk("R3 held line load", ramp, 10);
    wait_n(6);
    chk("R3 held line no restart", ramp, exp_ramp(10, 100, 50, 0, 6));
    trig[3] = 1'b0;
  endtask

  task automatic t_retrigger();
    setup(1, 0, 3, 500, 1, 3);
    pulse(3);
    wait_n(2);
    pulse(3);
    chk("R9 reload", ramp, 500);
    wait_n(1);
    chk("R9 fraction cleared k1", ramp, exp_ramp(500, 1, 3, 0, 1));
    wait_n(1);
    chk("R9 fraction cleared k2", ramp, exp_ramp(500, 1, 3, 0, 2));
  endtask

  task automatic t_zero_period();
    setup(1, 0, 3, 777, 200, 0);
    pulse(3);
    wait_n(10);
    chk("R10 zero period hold", ramp, 777);
  endtask

  task automatic t_disable_mid();
    setup(1, 0, 3, 40, 100, 50);
    pulse(3);
    wait_n(3);
    setup(0, 0, 3, 60, 100, 50);
    wait_n(1);
    chk("R11 valid drops", valid, 0);
    chk("R2 ramp to start", ramp, 60);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_rising();
    t_falling();
    t_sat_up();
    t_cfg_latch();
    t_other_line();
    t_retrigger();
    t_zero_period();
    t_disable_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule